// File: doc/BRIEF.md
# Cache Event Counter Bank

This block holds four independent 64-bit counters that software points at activity inside a cache controller. Each counter has its own event code and its own clear-on-read flag. Both are set through a small valid/ready register port, and the same port reads a counter's value back.

Activity reaches the block in two forms. The first is a vector of single-cycle pulses for the general events. The second is a set of small per-cycle occupancy counts, grouped by cache quadrant. A pulse event adds one to a counter for each cycle it is high. An occupancy event adds that cycle's count instead, for example the number of banks that are busy. Event codes outside the supported set leave the counter unchanged.

Changing a counter's configuration never disturbs its accumulated value. A read of a counter that has clear-on-read set starts the count again from that same cycle's increment, so no activity is lost across a read.

Top module: `cache_event_counters`

## Requirements
- R1: After reset every counter holds 0, every event code is 0, every clear-on-read flag is off, `rdValid` is low and `regReady` is high.
- R2: A request is accepted on a rising edge where `regValid` and `regReady` are both high. With `regWrite`=1 it loads counter `regSel` (0..3) with event code `regEvent` and clear-on-read flag `regClrOnRd`. With `regWrite`=0 it reads counter `regSel`.
- R3: `rdValid` is high for exactly one cycle, the cycle after the accepting edge. In that cycle `rdData` holds the 64-bit count the counter had just before that edge. `rdData` keeps this value until the next read.
- R4: Event codes 1 to 9 are pulse events. A counter with code c adds 1 on each edge where `evPulse[c]` is high.
- R5: Code 128+16q+k, with quadrant q in 0..3 and k in 0..3, is an occupancy event. It adds the 3-bit value `occLevel[(4q+k)*3 +: 3]` on each edge.
- R6: Code 0, codes 10 to 127, codes 128+16q+4 to 128+16q+15, and codes 192 and up add nothing.
- R7: A configuration write keeps the counter's accumulated value. The old code governs the accepting edge and the new code governs every later edge.
- R8: The four counters count independently, each by its own code, even when several of them are active in the same cycle.
- R9: A read of a counter with clear-on-read set returns its value and zeroes it. A read without the flag leaves the count unchanged.
- R10: When a clear-on-read read and an increment fall on the same edge, the counter afterwards holds exactly that edge's increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register request valid |
| regReady | output | 1 | Block can accept a request |
| regWrite | input | 1 | 1 = configure, 0 = read |
| regSel | input | 2 | Counter index 0..3 |
| regEvent | input | 8 | Event code for a configure request |
| regClrOnRd | input | 1 | Clear-on-read flag for a configure request |
| rdValid | output | 1 | Read data valid, one cycle |
| rdData | output | 64 | Count returned by a read |
| evPulse | input | 10 | Per-cycle pulse events; bit c is code c (bit 0 unused) |
| occLevel | input | 48 | Sixteen 3-bit occupancy counts, four per quadrant |

## Verification
Every increment lands in the counter on the edge that samples the event, so a counter reflects its events as soon as that edge has passed. The bench changes inputs on falling edges and lets a whole number of rising edges pass before any read. A read returns its data and raises `rdValid` one edge after acceptance. The bench samples both on the following falling edge and confirms that `rdValid` is low again one cycle later. For the same-edge case, the read and the increment are placed on one rising edge, and the bench expects the value from before that edge followed by a restart at one.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  localparam int NUM_CNT     = 4;
  localparam int CNT_W       = 64;
  localparam int CODE_W      = 8;
  localparam int NUM_PULSE   = 10;
  localparam int NUM_QUAD    = 4;
  localparam int EV_PER_QUAD = 4;
  localparam int OCC_W       = 3;
  localparam int QUAD_BASE   = 128;
  localparam int QUAD_STRIDE = 16;
  localparam int NUM_OCC     = NUM_QUAD * EV_PER_QUAD;
  localparam int SEL_W       = $clog2(NUM_CNT);

  typedef struct packed {
    logic [NUM_CNT-1:0] readHit;
    logic [NUM_CNT-1:0] clearHit;
  } ctlStrobe_t;

  // Amount one counter adds this cycle for a given code.
  function automatic logic [OCC_W-1:0] eventAmount(
    input logic [CODE_W-1:0]        code,
    input logic [NUM_PULSE-1:0]     pulses,
    input logic [NUM_OCC*OCC_W-1:0] occ
  );
    logic [OCC_W-1:0] amt;
    amt = '0;
    for (int p = 1; p < NUM_PULSE; p++) begin
      if (int'(code) == p) amt = {{(OCC_W-1){1'b0}}, pulses[p]};
    end
    for (int q = 0; q < NUM_QUAD; q++) begin
      for (int k = 0; k < EV_PER_QUAD; k++) begin
        if (int'(code) == QUAD_BASE + q*QUAD_STRIDE + k)
          amt = occ[(q*EV_PER_QUAD+k)*OCC_W +: OCC_W];
      end
    end
    return amt;
  endfunction
endpackage

// File: rtl/evcnt_ctrl.sv
module evcnt_ctrl
  import evcnt_pkg::*;
#(
  parameter int N_CNT = NUM_CNT,
  parameter int C_W   = CODE_W,
  localparam int S_W  = $clog2(N_CNT)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regValid,
  output logic                      regReady,
  input  logic                      regWrite,
  input  logic [S_W-1:0]            regSel,
  input  logic [C_W-1:0]            regEvent,
  input  logic                      regClrOnRd,
  output logic                      rdValid,
  output ctlStrobe_t                strobe,
  output logic [N_CNT-1:0][C_W-1:0] evCode
);
  logic [N_CNT-1:0] clrFlag;
  logic             accept;

  assign accept = regValid && regReady;

  always_comb begin
    strobe.readHit  = '0;
    strobe.clearHit = '0;
    for (int i = 0; i < N_CNT; i++) begin
      if (accept && !regWrite && int'(regSel) == i) begin
        strobe.readHit[i]  = 1'b1;
        strobe.clearHit[i] = clrFlag[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regReady <= 1'b0;
      rdValid  <= 1'b0;
      clrFlag  <= '0;
      evCode   <= '0;
    end else begin
      regReady <= 1'b1;
      rdValid  <= accept && !regWrite;
      if (accept && regWrite) begin
        evCode[regSel]  <= regEvent;
        clrFlag[regSel] <= regClrOnRd;
      end
    end
  end

  AST_RD_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regReady && !regWrite) |=> rdValid);              // R3
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !(regValid && regReady && !regWrite) |=> !rdValid);            // R3
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.readHit));                                     // R2
endmodule

// File: rtl/evcnt_datapath.sv
module evcnt_datapath
  import evcnt_pkg::*;
#(
  parameter int N_CNT = NUM_CNT,
  parameter int W     = CNT_W,
  parameter int C_W   = CODE_W,
  parameter int N_P   = NUM_PULSE,
  parameter int N_O   = NUM_OCC,
  parameter int O_W   = OCC_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobe_t                strobe,
  input  logic [N_CNT-1:0][C_W-1:0] evCode,
  input  logic [N_P-1:0]            evPulse,
  input  logic [N_O*O_W-1:0]        occLevel,
  output logic [W-1:0]              rdData
);
  logic [N_CNT-1:0][W-1:0] cnt;
  logic [W-1:0]            selCnt;

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    logic [O_W-1:0] amt;
    logic [W-1:0]   base;

    always_comb begin
      amt  = eventAmount(evCode[i], evPulse, occLevel);
      base = strobe.clearHit[i] ? '0 : cnt[i];
    end

    always_ff @(posedge clk) begin
      if (!rstN) cnt[i] <= '0;
      else       cnt[i] <= base + {{(W-O_W){1'b0}}, amt};
    end

    AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (!rstN)
      strobe.clearHit[i] |=> (cnt[i] < W'(1 << O_W)));              // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (evCode[i] == '0 && !strobe.clearHit[i]) |=> $stable(cnt[i])); // R6
  end

  always_comb begin
    selCnt = '0;
    for (int i = 0; i < N_CNT; i++) begin
      if (strobe.readHit[i]) selCnt = cnt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   rdData <= '0;
    else if (|strobe.readHit)    rdData <= selCnt;
  end
endmodule

// File: rtl/cache_event_counters.sv
module cache_event_counters
  import evcnt_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regValid,
  output logic                     regReady,
  input  logic                     regWrite,
  input  logic [SEL_W-1:0]         regSel,
  input  logic [CODE_W-1:0]        regEvent,
  input  logic                     regClrOnRd,
  output logic                     rdValid,
  output logic [CNT_W-1:0]         rdData,
  input  logic [NUM_PULSE-1:0]     evPulse,
  input  logic [NUM_OCC*OCC_W-1:0] occLevel
);
  ctlStrobe_t                       strobe;
  logic [NUM_CNT-1:0][CODE_W-1:0]   evCode;

  evcnt_ctrl #(.N_CNT(NUM_CNT), .C_W(CODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regReady(regReady),
    .regWrite(regWrite), .regSel(regSel), .regEvent(regEvent),
    .regClrOnRd(regClrOnRd), .rdValid(rdValid), .strobe(strobe),
    .evCode(evCode)
  );

  evcnt_datapath #(
    .N_CNT(NUM_CNT), .W(CNT_W), .C_W(CODE_W),
    .N_P(NUM_PULSE), .N_O(NUM_OCC), .O_W(OCC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .evCode(evCode),
    .evPulse(evPulse), .occLevel(occLevel), .rdData(rdData)
  );

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> $stable(rdData));                                  // R3
endmodule

// File: tb/cache_event_counters_test.sv
module cache_event_counters_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0;
  logic        regReady;
  logic        regWrite = 1'b0;
  logic [1:0]  regSel = '0;
  logic [7:0]  regEvent = '0;
  logic        regClrOnRd = 1'b0;
  logic        rdValid;
  logic [63:0] rdData;
  logic [9:0]  evPulse = '0;
  logic [47:0] occLevel = '0;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  cache_event_counters uut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regReady(regReady),
    .regWrite(regWrite), .regSel(regSel), .regEvent(regEvent),
    .regClrOnRd(regClrOnRd), .rdValid(rdValid), .rdData(rdData),
    .evPulse(evPulse), .occLevel(occLevel)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int sel, input int code, input logic clr);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regSel = 2'(sel);
    regEvent = 8'(code); regClrOnRd = clr;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic readCnt(input int sel, input string req, input logic [63:0] exp);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regSel = 2'(sel);
    @(negedge clk);
    regValid = 1'b0;
    chk("R3 rdValid", {63'd0, rdValid}, 64'd1);
    chk(req, rdData, exp);
    @(negedge clk);
    chk("R3 rdValid drop", {63'd0, rdValid}, 64'd0);
  endtask

  task automatic setOcc(input int q, input int k, input int v);
    occLevel[(q*4+k)*3 +: 3] = 3'(v);
  endtask

  task automatic testReset();
    chk("R1 regReady", {63'd0, regReady}, 64'd1);
    chk("R1 rdValid", {63'd0, rdValid}, 64'd0);
    for (int i = 0; i < 4; i++) readCnt(i, "R1 zero count", 64'd0);
  endtask

  task automatic testPulse();
    cfg(0, 3, 1'b0);
    cfg(1, 4, 1'b0);
    @(negedge clk);
    evPulse[3] = 1'b1; evPulse[4] = 1'b1;
    repeat (5) @(negedge clk);
    evPulse[3] = 1'b0;
    repeat (2) @(negedge clk);
    evPulse[4] = 1'b0;
    readCnt(0, "R4 pulse code 3", 64'd5);
    readCnt(1, "R8 pulse code 4", 64'd7);
    readCnt(0, "R9 no clear without flag", 64'd5);
  endtask

  task automatic testOcc();
    cfg(2, 130, 1'b0);
    cfg(3, 179, 1'b0);
    @(negedge clk);
    setOcc(0, 2, 3); setOcc(3, 3, 4); setOcc(1, 1, 7);
    repeat (2) @(negedge clk);
    setOcc(3, 3, 0);
    repeat (2) @(negedge clk);
    occLevel = '0;
    readCnt(2, "R5 quad0 occupancy", 64'd12);
    readCnt(3, "R5 quad3 occupancy", 64'd8);
  endtask

  task automatic testUnsupported();
    cfg(0, 132, 1'b0);
    cfg(1, 0, 1'b0);
    cfg(2, 10, 1'b0);
    cfg(3, 200, 1'b0);
    @(negedge clk);
    evPulse = '1; occLevel = '1;
    repeat (6) @(negedge clk);
    evPulse = '0; occLevel = '0;
    readCnt(0, "R6 quad gap code, R7 kept", 64'd5);
    readCnt(1, "R6 code 0, R7 kept", 64'd7);
    readCnt(2, "R6 code 10", 64'd12);
    readCnt(3, "R6 code 200", 64'd8);
  endtask

  task automatic testClear();
    cfg(0, 1, 1'b1);
    @(negedge clk);
    evPulse[1] = 1'b1;
    repeat (3) @(negedge clk);
    evPulse[1] = 1'b0;
    readCnt(0, "R9 clear-on-read value", 64'd8);
    readCnt(0, "R9 cleared after read", 64'd0);
  endtask

  task automatic testSameEdge();
    @(negedge clk);
    evPulse[1] = 1'b1;
    repeat (3) @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regSel = 2'd0;
    @(negedge clk);
    regValid = 1'b0; evPulse[1] = 1'b0;
    chk("R10 rdValid", {63'd0, rdValid}, 64'd1);
    chk("R10 value before edge", rdData, 64'd3);
    readCnt(0, "R10 restart at increment", 64'd1);
  endtask

  task automatic testCfgEdge();
    cfg(1, 0, 1'b0);
    readCnt(1, "R7 base", 64'd7);
    @(negedge clk);
    evPulse[2] = 1'b1;
    regValid = 1'b1; regWrite = 1'b1; regSel = 2'd1;
    regEvent = 8'd2; regClrOnRd = 1'b0;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
    repeat (2) @(negedge clk);
    evPulse[2] = 1'b0;
    readCnt(1, "R7 new code from next edge", 64'd9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testPulse();
    testOcc();
    testUnsupported();
    testClear();
    testSameEdge();
    testCfgEdge();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule